// File: doc/BRIEF.md
# Sequential Acceptance Filter Router

This block decides, for every received frame, whether it is kept and into which of two receive queues it goes. A small bank of filter pairs holds a mask and a reference identifier for each filter, together with an extended-format flag for each. Each pair has its own enable bit. When a frame identifier is offered, the router walks the filter bank one index per clock, starting at index 0. It stops at the first enabled filter whose masked reference equals the masked frame identifier.

The index of the winning filter is compared with a programmable partition index. Filters at or below the partition feed queue 0, and filters above it feed queue 1. If the chosen queue reports full, the frame is discarded and a sticky overflow flag for that queue is raised. The other queue is not consulted. A frame that no enabled filter accepts is discarded without touching the overflow flags. While a decision is pending, a busy output tells the receiver that new frames are not taken.

Filter storage has no reset. It is written through a simple write port, and a write to a filter whose enable bit is set is refused.

Top module: `accept_router`

Identifier layout: the 29-bit identifier carries the 11 standard bits in positions [28:18] and the 18 extension bits in [17:0].

Signal encodings:
- `store_sel` 0 selects queue 0 and 1 selects queue 1.
- `ovf_clr[0]` clears `ovf0`, and `ovf_clr[1]` clears `ovf1`.

## Requirements
- R1: With the filter mask-IDE bit at 1, a filter matches when `(frame_id & mask) == (ref_id & mask)` over all 29 bits. In addition, the frame IDE flag must equal the reference IDE flag.
- R2: With the filter mask-IDE bit at 0, only identifier bits [28:18] are compared under the mask. Bits [17:0] and the frame IDE flag have no effect on the match.
- R3: Filters are visited in rising index order, one per clock, and disabled filters never match. The first enabled match wins. A hit at index k gives a `store` or `drop` pulse exactly one cycle long, k+1 clocks after the edge that accepted the frame. `store` and `drop` are never high together.
- R4: A hit at an index less than or equal to `part_idx` is stored with `store_sel`=0. A hit above `part_idx` is stored with `store_sel`=1.
- R5: If the queue chosen by R4 is full, the router pulses `drop` instead of `store` and sets that queue's overflow flag (`ovf0` or `ovf1`) on the next edge. The other queue's full flag has no effect.
- R6: When no enabled filter matches, including when all enables are 0, `drop` pulses 8 clocks after acceptance. No overflow flag is set.
- R7: Overflow flags stay set until the matching `ovf_clr` bit is sampled high at a clock edge. A new overflow event takes priority over a clear in the same cycle.
- R8: `busy` rises on the edge that accepts a frame (`frm_valid` high while `busy` is low) and stays high through the decision cycle. A `frm_valid` seen while `busy` is high is ignored.
- R9: A filter write with `cfg_we` high takes effect only when that filter's enable bit is 0. Filter contents are not cleared by reset.
- R10: After reset, `busy`, `store`, `drop`, `ovf0` and `ovf1` are all 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Filter write strobe |
| cfg_idx | input | 3 | Filter index to write |
| cfg_mask | input | 29 | Mask identifier bits |
| cfg_mask_ide | input | 1 | Mask IDE bit (1: full extended compare) |
| cfg_fid | input | 29 | Reference identifier |
| cfg_fid_ide | input | 1 | Reference IDE flag |
| flt_en | input | 8 | Per-filter enable bits |
| part_idx | input | 3 | Partition index between the two queues |
| frm_valid | input | 1 | Frame identifier offered |
| frm_id | input | 29 | Frame identifier |
| frm_ide | input | 1 | Frame extended-format flag |
| fifo0_full | input | 1 | Queue 0 full |
| fifo1_full | input | 1 | Queue 1 full |
| ovf_clr | input | 2 | Overflow flag clear, bit per queue |
| busy | output | 1 | Decision in progress |
| store | output | 1 | Store pulse |
| store_sel | output | 1 | Queue select for store |
| drop | output | 1 | Frame discarded pulse |
| ovf0 | output | 1 | Sticky queue 0 overflow |
| ovf1 | output | 1 | Sticky queue 1 overflow |

## Verification
The bench checks the decision latency exactly, cycle by cycle. A design that did not skip disabled catch-all filters, or that did not stop at the first hit, would route to the wrong queue or report at the wrong cycle. The partition is tested at equality and after it is moved, so an off-by-one in the comparison would send the frame to the other queue. The full-queue cases set only the unchosen queue's full flag to prove it is ignored. The no-match case sets both full flags to prove that a miss never raises an overflow. A write to an enabled filter, and a frame offered while busy, are both shown to change nothing at the outputs.

// File: rtl/accept_router_pkg.sv
package accept_router_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_SCAN,
        ST_ROUTE,
        ST_MISS
    } rt_state_e;

endpackage

// File: rtl/accept_filter_bank.sv
module accept_filter_bank #(
    parameter int NUM_FILT = 8,
    parameter int ID_W     = 29,
    parameter int IDX_W    = 3
) (
    input  logic             clk,
    input  logic             cfg_we,
    input  logic [IDX_W-1:0] cfg_idx,
    input  logic [ID_W-1:0]  cfg_mask,
    input  logic             cfg_mask_ide,
    input  logic [ID_W-1:0]  cfg_fid,
    input  logic             cfg_fid_ide,
    input  logic [NUM_FILT-1:0] flt_en,
    input  logic [IDX_W-1:0] rd_idx,
    output logic [ID_W-1:0]  rd_mask,
    output logic             rd_mask_ide,
    output logic [ID_W-1:0]  rd_fid,
    output logic             rd_fid_ide
);

    logic [ID_W-1:0] mask_q [NUM_FILT];
    logic [ID_W-1:0] fid_q  [NUM_FILT];
    logic [NUM_FILT-1:0] mask_ide_q;
    logic [NUM_FILT-1:0] fid_ide_q;

    // Storage holds no reset; a write is refused while the entry is enabled.
    for (genvar g = 0; g < NUM_FILT; g++) begin : g_entry
        logic wr_ok;
        assign wr_ok = cfg_we && (cfg_idx == IDX_W'(g)) && !flt_en[g];
        always_ff @(posedge clk) begin
            if (wr_ok) begin
                mask_q[g]     <= cfg_mask;
                mask_ide_q[g] <= cfg_mask_ide;
                fid_q[g]      <= cfg_fid;
                fid_ide_q[g]  <= cfg_fid_ide;
            end
        end
    end

    always_comb begin
        rd_mask     = mask_q[rd_idx];
        rd_mask_ide = mask_ide_q[rd_idx];
        rd_fid      = fid_q[rd_idx];
        rd_fid_ide  = fid_ide_q[rd_idx];
    end

endmodule

// File: rtl/accept_match.sv
module accept_match #(
    parameter int ID_W  = 29,
    parameter int STD_W = 11
) (
    input  logic [ID_W-1:0] frm_id,
    input  logic            frm_ide,
    input  logic [ID_W-1:0] flt_mask,
    input  logic            flt_mask_ide,
    input  logic [ID_W-1:0] flt_fid,
    input  logic            flt_fid_ide,
    output logic            hit
);

    localparam int EXT_W = ID_W - STD_W;
    localparam logic [ID_W-1:0] STD_ONLY = {{STD_W{1'b1}}, {EXT_W{1'b0}}};

    logic [ID_W-1:0] eff_mask;
    logic [ID_W-1:0] frm_masked;
    logic [ID_W-1:0] ref_masked;
    logic            ide_ok;

    always_comb begin
        eff_mask   = flt_mask_ide ? flt_mask : (flt_mask & STD_ONLY);
        frm_masked = frm_id & eff_mask;
        ref_masked = flt_fid & eff_mask;
        ide_ok     = !flt_mask_ide || (frm_ide == flt_fid_ide);
        hit        = (frm_masked == ref_masked) && ide_ok;
    end

endmodule

// File: rtl/accept_route_fsm.sv
module accept_route_fsm
    import accept_router_pkg::*;
#(
    parameter int NUM_FILT = 8,
    parameter int IDX_W    = 3
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                frm_valid,
    input  logic                cand_hit,
    input  logic [NUM_FILT-1:0] flt_en,
    input  logic [IDX_W-1:0]    part_idx,
    input  logic                fifo0_full,
    input  logic                fifo1_full,
    input  logic [1:0]          ovf_clr,
    output logic [IDX_W-1:0]    scan_idx,
    output logic                accept,
    output logic                busy,
    output logic                store,
    output logic                store_sel,
    output logic                drop,
    output logic                ovf0,
    output logic                ovf1
);

    localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_FILT - 1);

    rt_state_e        state_q, state_d;
    logic [IDX_W-1:0] scan_q, scan_d;
    logic [IDX_W-1:0] hit_q, hit_d;
    logic             cand_ok;
    logic             to_q1;
    logic             sel_full;
    logic             set0, set1;

    assign cand_ok  = cand_hit && flt_en[scan_q];
    assign scan_idx = scan_q;

    always_comb begin
        state_d = state_q;
        scan_d  = scan_q;
        hit_d   = hit_q;
        unique case (state_q)
            ST_IDLE: begin
                if (frm_valid) begin
                    state_d = ST_SCAN;
                    scan_d  = '0;
                end
            end
            ST_SCAN: begin
                if (cand_ok) begin
                    state_d = ST_ROUTE;
                    hit_d   = scan_q;
                end else if (scan_q == LAST_IDX) begin
                    state_d = ST_MISS;
                end else begin
                    scan_d = scan_q + 1'b1;
                end
            end
            ST_ROUTE: state_d = ST_IDLE;
            ST_MISS:  state_d = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_IDLE;
            scan_q  <= '0;
            hit_q   <= '0;
        end else begin
            state_q <= state_d;
            scan_q  <= scan_d;
            hit_q   <= hit_d;
        end
    end

    always_comb begin
        busy      = (state_q != ST_IDLE);
        accept    = (state_q == ST_IDLE) && frm_valid;
        to_q1     = (hit_q > part_idx);
        sel_full  = to_q1 ? fifo1_full : fifo0_full;
        store     = (state_q == ST_ROUTE) && !sel_full;
        store_sel = (state_q == ST_ROUTE) && to_q1;
        drop      = (state_q == ST_MISS) || ((state_q == ST_ROUTE) && sel_full);
        set0      = (state_q == ST_ROUTE) && !to_q1 && fifo0_full;
        set1      = (state_q == ST_ROUTE) && to_q1 && fifo1_full;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ovf0 <= 1'b0;
            ovf1 <= 1'b0;
        end else begin
            ovf0 <= (ovf0 && !ovf_clr[0]) || set0;
            ovf1 <= (ovf1 && !ovf_clr[1]) || set1;
        end
    end

endmodule

// File: rtl/accept_router.sv
module accept_router #(
    parameter int NUM_FILT = 8,
    parameter int ID_W     = 29,
    parameter int STD_W    = 11,
    parameter int IDX_W    = $clog2(NUM_FILT)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cfg_we,
    input  logic [IDX_W-1:0]    cfg_idx,
    input  logic [ID_W-1:0]     cfg_mask,
    input  logic                cfg_mask_ide,
    input  logic [ID_W-1:0]     cfg_fid,
    input  logic                cfg_fid_ide,
    input  logic [NUM_FILT-1:0] flt_en,
    input  logic [IDX_W-1:0]    part_idx,
    input  logic                frm_valid,
    input  logic [ID_W-1:0]     frm_id,
    input  logic                frm_ide,
    input  logic                fifo0_full,
    input  logic                fifo1_full,
    input  logic [1:0]          ovf_clr,
    output logic                busy,
    output logic                store,
    output logic                store_sel,
    output logic                drop,
    output logic                ovf0,
    output logic                ovf1
);

    logic [IDX_W-1:0] scan_idx;
    logic             accept;
    logic [ID_W-1:0]  lat_id;
    logic             lat_ide;
    logic [ID_W-1:0]  rd_mask;
    logic             rd_mask_ide;
    logic [ID_W-1:0]  rd_fid;
    logic             rd_fid_ide;
    logic             cand_hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lat_id  <= '0;
            lat_ide <= 1'b0;
        end else if (accept) begin
            lat_id  <= frm_id;
            lat_ide <= frm_ide;
        end
    end

    accept_filter_bank #(
        .NUM_FILT (NUM_FILT),
        .ID_W     (ID_W),
        .IDX_W    (IDX_W)
    ) u_bank (
        .clk          (clk),
        .cfg_we       (cfg_we),
        .cfg_idx      (cfg_idx),
        .cfg_mask     (cfg_mask),
        .cfg_mask_ide (cfg_mask_ide),
        .cfg_fid      (cfg_fid),
        .cfg_fid_ide  (cfg_fid_ide),
        .flt_en       (flt_en),
        .rd_idx       (scan_idx),
        .rd_mask      (rd_mask),
        .rd_mask_ide  (rd_mask_ide),
        .rd_fid       (rd_fid),
        .rd_fid_ide   (rd_fid_ide)
    );

    accept_match #(
        .ID_W  (ID_W),
        .STD_W (STD_W)
    ) u_match (
        .frm_id       (lat_id),
        .frm_ide      (lat_ide),
        .flt_mask     (rd_mask),
        .flt_mask_ide (rd_mask_ide),
        .flt_fid      (rd_fid),
        .flt_fid_ide  (rd_fid_ide),
        .hit          (cand_hit)
    );

    accept_route_fsm #(
        .NUM_FILT (NUM_FILT),
        .IDX_W    (IDX_W)
    ) u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .frm_valid  (frm_valid),
        .cand_hit   (cand_hit),
        .flt_en     (flt_en),
        .part_idx   (part_idx),
        .fifo0_full (fifo0_full),
        .fifo1_full (fifo1_full),
        .ovf_clr    (ovf_clr),
        .scan_idx   (scan_idx),
        .accept     (accept),
        .busy       (busy),
        .store      (store),
        .store_sel  (store_sel),
        .drop       (drop),
        .ovf0       (ovf0),
        .ovf1       (ovf1)
    );

endmodule

// File: rtl/accept_router_chk.sv
module accept_router_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       frm_valid,
    input logic       fifo0_full,
    input logic       fifo1_full,
    input logic [1:0] ovf_clr,
    input logic       busy,
    input logic       store,
    input logic       store_sel,
    input logic       drop,
    input logic       ovf0,
    input logic       ovf1
);

    p_excl_strobe_r3: assert property (@(posedge clk) disable iff (!rst_n)
        !(store && drop));

    p_pulse_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (store || drop) |=> !(store || drop));

    p_strobe_busy_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (store || drop) |-> busy);

    p_accept_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy && frm_valid) |=> busy);

    p_store_q0_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (store && !store_sel) |-> !fifo0_full);

    p_store_q1_room_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (store && store_sel) |-> !fifo1_full);

    p_ovf0_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf0 && !ovf_clr[0]) |=> ovf0);

    p_ovf1_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (ovf1 && !ovf_clr[1]) |=> ovf1);

    p_ovf0_cause_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!ovf0 && !(drop && !store_sel && fifo0_full)) |=> !ovf0);

endmodule

bind accept_router accept_router_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .frm_valid  (frm_valid),
    .fifo0_full (fifo0_full),
    .fifo1_full (fifo1_full),
    .ovf_clr    (ovf_clr),
    .busy       (busy),
    .store      (store),
    .store_sel  (store_sel),
    .drop       (drop),
    .ovf0       (ovf0),
    .ovf1       (ovf1)
);

// File: tb/accept_router_bench.sv
module accept_router_bench;

    localparam int NF = 8;
    localparam int IW = 29;
    localparam int XW = 3;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          cfg_we = 1'b0;
    logic [XW-1:0] cfg_idx = '0;
    logic [IW-1:0] cfg_mask = '0;
    logic          cfg_mask_ide = 1'b0;
    logic [IW-1:0] cfg_fid = '0;
    logic          cfg_fid_ide = 1'b0;
    logic [NF-1:0] flt_en = '0;
    logic [XW-1:0] part_idx = 3'd1;
    logic          frm_valid = 1'b0;
    logic [IW-1:0] frm_id = '0;
    logic          frm_ide = 1'b0;
    logic          fifo0_full = 1'b0;
    logic          fifo1_full = 1'b0;
    logic [1:0]    ovf_clr = 2'b00;
    logic          busy, store, store_sel, drop, ovf0, ovf1;

    int checks = 0;
    int errors = 0;
    int cycles = 0;

    always #2 clk = ~clk;

    accept_router u_accept_router (
        .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_idx(cfg_idx),
        .cfg_mask(cfg_mask), .cfg_mask_ide(cfg_mask_ide), .cfg_fid(cfg_fid),
        .cfg_fid_ide(cfg_fid_ide), .flt_en(flt_en), .part_idx(part_idx),
        .frm_valid(frm_valid), .frm_id(frm_id), .frm_ide(frm_ide),
        .fifo0_full(fifo0_full), .fifo1_full(fifo1_full), .ovf_clr(ovf_clr),
        .busy(busy), .store(store), .store_sel(store_sel), .drop(drop),
        .ovf0(ovf0), .ovf1(ovf1)
    );

    always @(posedge clk) begin
        cycles <= cycles + 1;
        if (cycles > 50000) begin
            errors = errors + 1;
            $display("FAIL watchdog expired");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic wr_filt(input int idx, input logic [IW-1:0] m, input logic mi,
                           input logic [IW-1:0] f, input logic fi);
        @(negedge clk);
        cfg_we = 1'b1; cfg_idx = XW'(idx);
        cfg_mask = m; cfg_mask_ide = mi; cfg_fid = f; cfg_fid_ide = fi;
        @(negedge clk);
        cfg_we = 1'b0;
    endtask

    task automatic clr_ovf();
        @(negedge clk);
        ovf_clr = 2'b11;
        @(negedge clk);
        ovf_clr = 2'b00;
    endtask

    // kind: 0 store queue 0, 1 store queue 1, 2 drop; lat counted in falling edges
    task automatic run_frame(input logic [IW-1:0] id, input logic ide, input logic [1:0] full,
                             output int kind, output int lat, output logic [1:0] ovf,
                             output logic busy_seen);
        @(negedge clk);
        frm_valid = 1'b1; frm_id = id; frm_ide = ide;
        fifo0_full = full[0]; fifo1_full = full[1];
        @(negedge clk);
        frm_valid = 1'b0;
        lat = 1;
        busy_seen = busy;
        while (!(store || drop) && lat < 20) begin
            @(negedge clk);
            lat++;
        end
        kind = drop ? 2 : (store ? int'(store_sel) : 3);
        @(negedge clk);
        ovf = {ovf1, ovf0};
        fifo0_full = 1'b0; fifo1_full = 1'b0;
    endtask

    // id[39:11] ide[10] full[9:8] kind[7:6] lat[5:2] ovf[1:0]
    localparam logic [39:0] VEC [8] = '{
        {29'h0ABCDEF,  1'b1, 2'b00, 2'd0, 4'd2, 2'b00},  // R1 exact extended, filter 0
        {29'h0ABCDEF,  1'b0, 2'b00, 2'd1, 4'd7, 2'b00},  // R1 IDE mismatch, skips disabled 2,4
        {29'h48C0055,  1'b0, 2'b00, 2'd0, 4'd3, 2'b00},  // R2 standard match at partition
        {29'h48C0055,  1'b1, 2'b00, 2'd0, 4'd3, 2'b00},  // R2 IDE ignored
        {29'h15555555, 1'b1, 2'b00, 2'd1, 4'd5, 2'b00},  // R4 above partition
        {29'h0ABCDEF,  1'b1, 2'b01, 2'd2, 4'd2, 2'b01},  // R5 queue 0 full
        {29'h15555555, 1'b1, 2'b10, 2'd2, 4'd5, 2'b10},  // R5 queue 1 full
        {29'h0ABCDEF,  1'b1, 2'b10, 2'd0, 4'd2, 2'b00}   // R5 other queue full ignored
    };

    initial begin
        int k, l;
        logic [1:0] ov;
        logic bz;
        int strobes;

        repeat (3) @(negedge clk);
        // R10 reset state
        check({busy, store, drop, ovf0, ovf1} == 5'b0, "R10 reset outputs",
              {busy, store, drop, ovf0, ovf1}, 0);
        rst_n = 1'b1;

        // R9 writes while disabled
        wr_filt(0, 29'h1FFFFFFF, 1'b1, 29'h0ABCDEF, 1'b1);
        wr_filt(1, 29'h1FFC0000, 1'b0, 29'h48C0000, 1'b0);
        wr_filt(2, 29'h0,        1'b0, 29'h0,       1'b0);
        wr_filt(3, 29'h1E000000, 1'b1, 29'h14000000, 1'b1);
        wr_filt(4, 29'h0,        1'b0, 29'h0,       1'b0);
        wr_filt(5, 29'h0,        1'b0, 29'h0,       1'b0);
        wr_filt(6, 29'h0,        1'b0, 29'h0,       1'b0);
        wr_filt(7, 29'h0,        1'b0, 29'h0,       1'b0);
        flt_en = 8'b0010_1011;

        for (int i = 0; i < 8; i++) begin
            clr_ovf();
            run_frame(VEC[i][39:11], VEC[i][10], VEC[i][9:8], k, l, ov, bz);
            check(k == int'(VEC[i][7:6]), $sformatf("R3/R4/R5 vec%0d kind", i), k, VEC[i][7:6]);
            check(l == int'(VEC[i][5:2]), $sformatf("R3 vec%0d latency", i), l, VEC[i][5:2]);
            check(ov == VEC[i][1:0], $sformatf("R5 vec%0d overflow", i), ov, VEC[i][1:0]);
        end

        // R7 sticky: ovf1 set by last-but-one vector was cleared; raise ovf0, then store
        clr_ovf();
        run_frame(29'h0ABCDEF, 1'b1, 2'b01, k, l, ov, bz);
        run_frame(29'h0ABCDEF, 1'b1, 2'b00, k, l, ov, bz);
        check(ov == 2'b01, "R7 ovf0 held across later store", ov, 1);
        @(negedge clk); ovf_clr = 2'b10; @(negedge clk); ovf_clr = 2'b00;
        check({ovf1, ovf0} == 2'b01, "R7 clear of other flag leaves ovf0", {ovf1, ovf0}, 1);
        clr_ovf();
        check({ovf1, ovf0} == 2'b00, "R7 clear", {ovf1, ovf0}, 0);

        // R9 write to enabled filter 0 ignored
        wr_filt(0, 29'h1FFFFFFF, 1'b1, 29'h0000001, 1'b1);
        run_frame(29'h0ABCDEF, 1'b1, 2'b00, k, l, ov, bz);
        check(k == 0 && l == 2, "R9 enabled filter write refused", l, 2);

        // R4 partition moved up: filter 3 now feeds queue 0
        part_idx = 3'd3;
        run_frame(29'h15555555, 1'b1, 2'b00, k, l, ov, bz);
        check(k == 0, "R4 index equal to moved partition", k, 0);
        part_idx = 3'd1;

        // R6 no match: catch-all disabled, both queues full
        flt_en = 8'b0000_1011;
        run_frame(29'h0ABCDEF, 1'b0, 2'b11, k, l, ov, bz);
        check(k == 2 && l == 9, "R6 miss drop latency", l, 9);
        check(ov == 2'b00, "R6 miss leaves overflow clear", ov, 0);

        // R6 all disabled
        flt_en = 8'b0;
        run_frame(29'h0ABCDEF, 1'b1, 2'b00, k, l, ov, bz);
        check(k == 2 && l == 9, "R6 all disabled drops", k, 2);
        flt_en = 8'b0010_1011;

        // R8 busy and a second frame offered mid-scan
        @(negedge clk);
        frm_valid = 1'b1; frm_id = 29'h0ABCDEF; frm_ide = 1'b0;
        @(negedge clk);
        check(busy == 1'b1, "R8 busy after accept", busy, 1);
        frm_id = 29'h48C0000; frm_ide = 1'b0;
        @(negedge clk);
        frm_valid = 1'b0;
        strobes = 0;
        for (int c = 0; c < 20; c++) begin
            if (store || drop) begin
                strobes++;
                check(store && store_sel, "R8 first frame routed to queue 1", store_sel, 1);
            end
            @(negedge clk);
        end
        check(strobes == 1, "R8 frame during busy ignored", strobes, 1);
        check(busy == 1'b0, "R8 busy released", busy, 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule